// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a serial audio stream made of a bit clock, a frame clock and four data lanes, and turns it into parallel sample words. Each word leaves on `sample_o` with a one-cycle `valid_o` pulse and a channel number on `chan_o`. The block is always a clock slave. The bit clock, frame clock and data lines come from outside and pass through two-flop synchronisers into the system clock domain. Bit-clock edges are then found by comparing successive synchronised samples. The system clock must run at least four times as fast as the bit clock, which covers 192 kHz stereo or TDM streams with a system clock of a few hundred MHz.

A static `mode_i` input picks the framing:
- **I2S:** the word starts one bit clock late.
- **Left-justified:** the word starts on the first bit clock of the half frame.
- **Right-justified:** `wlen_i` sets the word length, and the MSB comes late enough that the LSB lands on the last bit clock of the half frame.
- **TDM:** eight 32-bit slots on lane 0.

In every stereo mode, all four lanes are captured in parallel. Their words are handed out on consecutive system-clock cycles once the last bit of a half frame has arrived. Every sample is left-aligned into 24 bits.

Top module: `audio_serial_rx`

## Requirements
- R1: `mode_i` is encoded as 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = TDM. The frame clock and every data lane are sampled on bit-clock rising edges. Each half frame is 32 bit clocks long. In I2S mode the MSB is sampled on the second rising edge after the frame clock changes level, and the 24 bits that follow form the word.
- R2: In left-justified mode the MSB is the bit sampled on the first rising edge at which the frame clock shows its new level.
- R3: In right-justified mode, `wlen_i` selects the word length: 0 = 24, 1 = 20, 2 = 18, 3 = 16 bits. The MSB is sampled 8, 12, 14 or 16 bit clocks after the first bit clock of the half frame, respectively. Bits outside the word are ignored.
- R4: Words shorter than 24 bits appear on `sample_o` left-aligned, with zeros in the unused LSBs. Longer slots are cut to their top 24 bits.
- R5: In stereo modes, lane k produces channel 2k for the left half and 2k+1 for the right half. The left half is frame clock low in I2S mode and frame clock high in the justified modes.
- R6: After each stereo half frame, the four lane words come out on four consecutive system-clock cycles in lane order 0 to 3. Each is marked by a one-cycle `valid_o` pulse.
- R7: In TDM mode, a frame starts at the bit clock where the frame clock rises. Lane 0 carries slots 0 to 7, each 32 bits, and slot n is reported as channel n from its top 24 bits. Lanes 1 to 3 produce no output.
- R8: While `rst_ni` is low, `valid_o`, `sample_o` and `chan_o` are zero. After reset, nothing is emitted until the frame clock has made a framing transition, so a steady frame clock yields no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External serial bit clock |
| lrclk_i | input | 1 | External frame (left/right) clock |
| sdata_i | input | 4 | Serial data lanes 0 to 3 |
| mode_i | input | 2 | Framing select (static) |
| wlen_i | input | 2 | Right-justified word length select (static) |
| sample_o | output | 24 | Captured sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for `sample_o` |
| chan_o | output | 3 | Channel number of `sample_o` |

## Verification
Each stereo framing is driven with different word values on all four lanes in both halves. Bits outside the word window carry an alternating junk pattern, so a window that is off by one position in either direction corrupts the data check instead of passing silently.

Right-justified mode is run at all four word lengths. This separates the four MSB offsets and confirms that the padding LSBs are zero. Two I2S runs with different seeds catch stuck bits.

A TDM frame with busy data on lanes 1 to 3 shows that the slot order is correct and that only lane 0 contributes. A period with a running bit clock and a steady frame clock, right after reset, shows that nothing is emitted before framing is found.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    MODE_I2S = 2'd0,
    MODE_LJ  = 2'd1,
    MODE_RJ  = 2'd2,
    MODE_TDM = 2'd3
  } fmt_e;

  // right-justified word length select
  function automatic int unsigned rj_word_bits(input logic [1:0] wl);
    case (wl)
      2'd0:    return 24;
      2'd1:    return 20;
      2'd2:    return 18;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned TDM_SLOTS = 8,
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned CH_W      = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bclk_i,
  input  logic                        lrclk_i,
  input  logic [1:0]                  mode_i,
  input  logic [1:0]                  wlen_i,
  output logic                        wr_o,
  output logic                        first_o,
  output logic [$clog2(SAMPLE_W)-1:0] bitpos_o,
  output logic                        done_o,
  output logic [CH_W-1:0]             chan_base_o,
  output logic                        tdm_o
);

  localparam int unsigned POS_W = $clog2(SLOT_BITS);
  localparam int unsigned CNT_W = $clog2(SLOT_BITS * TDM_SLOTS);
  localparam int unsigned OW    = POS_W + 1;
  localparam int unsigned BP_W  = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_BITS * TDM_SLOTS - 1);

  logic             bclk_q, lr_prev, primed, locked;
  logic             bit_ev, is_tdm, start, in_half, win, last, right;
  logic [CNT_W-1:0] cnt, idx;
  logic [POS_W-1:0] in_slot;
  logic [CNT_W-POS_W-1:0] slot;
  logic [OW-1:0]    off, wbits, rel, bp_full;

  always_comb begin
    bit_ev = bclk_i & ~bclk_q;
    is_tdm = (mode_i == MODE_TDM);
    // framing point: any level change in stereo, rising edge in TDM
    start  = primed & (is_tdm ? (lrclk_i & ~lr_prev) : (lrclk_i ^ lr_prev));
    if (start)               idx = '0;
    else if (cnt == CNT_MAX) idx = cnt;
    else                     idx = cnt + 1'b1;
    in_slot = idx[POS_W-1:0];
    slot    = idx[CNT_W-1:POS_W];
    in_half = is_tdm | (idx < CNT_W'(SLOT_BITS));
    wbits   = (mode_i == MODE_RJ) ? OW'(rj_word_bits(wlen_i)) : OW'(SAMPLE_W);
    case (fmt_e'(mode_i))
      MODE_I2S: off = OW'(1);
      MODE_RJ:  off = OW'(SLOT_BITS) - wbits;
      default:  off = '0;
    endcase
    rel     = {1'b0, in_slot} - off;
    win     = in_half && ({1'b0, in_slot} >= off) && (rel < wbits);
    last    = (rel == wbits - 1'b1);
    bp_full = OW'(SAMPLE_W - 1) - rel;
    right   = (mode_i == MODE_I2S) ? lrclk_i : ~lrclk_i;
    wr_o     = bit_ev & (locked | start) & win;
    first_o  = (rel == '0);
    bitpos_o = bp_full[BP_W-1:0];
    tdm_o    = is_tdm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q      <= 1'b0;
      lr_prev     <= 1'b0;
      primed      <= 1'b0;
      locked      <= 1'b0;
      cnt         <= CNT_MAX;
      done_o      <= 1'b0;
      chan_base_o <= '0;
    end else begin
      bclk_q <= bclk_i;
      done_o <= wr_o & last;
      if (wr_o && last) chan_base_o <= is_tdm ? CH_W'(slot) : CH_W'(right);
      if (bit_ev) begin
        lr_prev <= lrclk_i;
        primed  <= 1'b1;
        cnt     <= idx;
        locked  <= locked | start;
      end
    end
  end

endmodule

// File: rtl/aud_rx_lane.sv
module aud_rx_lane #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic                        first_i,
  input  logic [$clog2(SAMPLE_W)-1:0] bitpos_i,
  input  logic                        bit_i,
  output logic [SAMPLE_W-1:0]         word_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
    end else if (wr_i) begin
      // first bit clears the padding left from the previous word
      if (first_i) word_o <= '0;
      word_o[bitpos_i] <= bit_i;
    end
  end

endmodule

// File: rtl/aud_rx_emit.sv
module aud_rx_emit #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CH_W     = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           done_i,
  input  logic                           tdm_i,
  input  logic [CH_W-1:0]                chan_base_i,
  input  logic [LANES-1:0][SAMPLE_W-1:0] words_i,
  output logic [SAMPLE_W-1:0]            sample_o,
  output logic                           valid_o,
  output logic [CH_W-1:0]                chan_o
);

  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][SAMPLE_W-1:0] hold;
  logic [LANES-1:0]               pend;
  logic [CH_W-1:0]                base;
  logic                           tdm_q, any;
  logic [SEL_W-1:0]               sel;

  always_comb begin
    any = |pend;
    sel = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pend[k]) sel = SEL_W'(k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold     <= '0;
      pend     <= '0;
      base     <= '0;
      tdm_q    <= 1'b0;
      sample_o <= '0;
      valid_o  <= 1'b0;
      chan_o   <= '0;
    end else if (done_i) begin
      hold    <= words_i;
      pend    <= tdm_i ? LANES'(1) : '1;
      base    <= chan_base_i;
      tdm_q   <= tdm_i;
      valid_o <= 1'b0;
    end else if (any) begin
      sample_o  <= hold[sel];
      chan_o    <= tdm_q ? base : (CH_W'({sel, 1'b0}) | CH_W'(base[0]));
      valid_o   <= 1'b1;
      pend[sel] <= 1'b0;
    end else begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned TDM_SLOTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bclk_i,
  input  logic                 lrclk_i,
  input  logic [LANES-1:0]     sdata_i,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           wlen_i,
  output logic [SAMPLE_W-1:0]  sample_o,
  output logic                 valid_o,
  output logic [$clog2((2*LANES > TDM_SLOTS) ? 2*LANES : TDM_SLOTS)-1:0] chan_o
);

  localparam int unsigned CH_W  = $clog2((2*LANES > TDM_SLOTS) ? 2*LANES : TDM_SLOTS);
  localparam int unsigned BP_W  = $clog2(SAMPLE_W);
  localparam int unsigned SYN_W = LANES + 2;

  logic [SYN_W-1:0]               syn_q;
  logic                           wr, first, done, tdm;
  logic [BP_W-1:0]                bitpos;
  logic [CH_W-1:0]                chan_base;
  logic [LANES-1:0][SAMPLE_W-1:0] words;

  aud_rx_sync #(.W(SYN_W)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdata_i, lrclk_i, bclk_i}),
    .q_o    (syn_q)
  );

  aud_rx_framer #(
    .SLOT_BITS (SLOT_BITS),
    .TDM_SLOTS (TDM_SLOTS),
    .SAMPLE_W  (SAMPLE_W),
    .CH_W      (CH_W)
  ) i_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bclk_i      (syn_q[0]),
    .lrclk_i     (syn_q[1]),
    .mode_i      (mode_i),
    .wlen_i      (wlen_i),
    .wr_o        (wr),
    .first_o     (first),
    .bitpos_o    (bitpos),
    .done_o      (done),
    .chan_base_o (chan_base),
    .tdm_o       (tdm)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aud_rx_lane #(.SAMPLE_W(SAMPLE_W)) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr),
      .first_i  (first),
      .bitpos_i (bitpos),
      .bit_i    (syn_q[2+g]),
      .word_o   (words[g])
    );
  end

  aud_rx_emit #(
    .LANES    (LANES),
    .SAMPLE_W (SAMPLE_W),
    .CH_W     (CH_W)
  ) i_emit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .tdm_i       (tdm),
    .chan_base_i (chan_base),
    .words_i     (words),
    .sample_o    (sample_o),
    .valid_o     (valid_o),
    .chan_o      (chan_o)
  );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk
  import aud_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CH_W     = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          mode_i,
  input logic [1:0]          wlen_i,
  input logic                valid_o,
  input logic [CH_W-1:0]     chan_o,
  input logic [SAMPLE_W-1:0] sample_o
);

  logic [SAMPLE_W-1:0] pad_mask;
  logic                stereo;

  always_comb begin
    pad_mask = (SAMPLE_W'(1) << (SAMPLE_W - rj_word_bits(wlen_i))) - SAMPLE_W'(1);
    stereo   = (mode_i != MODE_TDM);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_QUIET: assert (!valid_o); // R8
    end
  end

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && stereo) |-> (chan_o == $past(chan_o) + CH_W'(2))); // R6

  AST_BURST_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(valid_o) && stereo) |-> ((chan_o >> 1) == '0)); // R5

  AST_TDM_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !stereo) |=> !valid_o); // R7

  AST_RJ_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_i == MODE_RJ) |-> ((sample_o & pad_mask) == '0)); // R4

endmodule

bind audio_serial_rx aud_rx_chk #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) i_aud_rx_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .wlen_i   (wlen_i),
  .valid_o  (valid_o),
  .chan_o   (chan_o),
  .sample_o (sample_o)
);

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_i = 1'b0;
  logic        lrclk_i = 1'b0;
  logic [3:0]  sdata_i = '0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  wlen_i = '0;
  logic [23:0] sample_o;
  logic        valid_o;
  logic [2:0]  chan_o;

  int          n_chk = 0;
  int          n_fail = 0;
  int          rx_n = 0;
  bit          fin = 1'b0;
  logic [23:0] rx_d [16];
  logic [2:0]  rx_c [16];

  always #4 clk_i = ~clk_i;

  audio_serial_rx i_audio_serial_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_i   (bclk_i),
    .lrclk_i  (lrclk_i),
    .sdata_i  (sdata_i),
    .mode_i   (mode_i),
    .wlen_i   (wlen_i),
    .sample_o (sample_o),
    .valid_o  (valid_o),
    .chan_o   (chan_o)
  );

  always @(negedge clk_i) begin
    if (valid_o) begin
      if (rx_n < 16) begin
        rx_d[rx_n] = sample_o;
        rx_c[rx_n] = chan_o;
      end
      rx_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wbits_of(input logic [1:0] wl);
    case (wl)
      2'd0:    return 24;
      2'd1:    return 20;
      2'd2:    return 18;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] mk_word(input int lane, input int h, input int seed, input int w);
    logic [31:0] v;
    v = (seed * 32'h9E3779B1) ^ (lane * 32'h01357913) ^ (h * 32'h00C3A5F1);
    return v[27:4] & ~((24'd1 << (24 - w)) - 24'd1);
  endfunction

  // data and frame clock change at the falling edge, sampled at the rising edge
  task automatic bit_cycle(input logic lr, input logic [3:0] d);
    bclk_i = 1'b0; lrclk_i = lr; sdata_i = d;
    #32;
    bclk_i = 1'b1;
    #32;
  endtask

  task automatic run_reset_quiet();
    rst_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    check(valid_o == 1'b0 && sample_o == '0 && chan_o == '0, "R8", "outputs in reset",
          {7'd0, valid_o, sample_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    mode_i = 2'd1;
    rx_n = 0;
    repeat (40) bit_cycle(1'b1, 4'hF);
    check(rx_n == 0, "R8", "samples with steady frame clock", 32'(rx_n), 32'd0);
  endtask

  task automatic run_stereo(input logic [1:0] md, input logic [1:0] wl, input int seed,
                            input string req);
    int w, off, pos;
    logic lvl_l, lr;
    logic [23:0] ex [4][2];
    logic [3:0] d;
    @(negedge clk_i);
    mode_i = md; wlen_i = wl;
    w   = (md == 2'd2) ? wbits_of(wl) : 24;
    off = (md == 2'd0) ? 1 : (md == 2'd2) ? 32 - w : 0;
    lvl_l = (md == 2'd0) ? 1'b0 : 1'b1;
    for (int k = 0; k < 4; k++)
      for (int h = 0; h < 2; h++) ex[k][h] = mk_word(k, h, seed, w);
    repeat (4) bit_cycle(~lvl_l, 4'h0);
    rx_n = 0;
    for (int h = 0; h < 2; h++) begin
      lr = (h == 0) ? lvl_l : ~lvl_l;
      for (int i = 0; i < 32; i++) begin
        pos = i - off;
        for (int k = 0; k < 4; k++)
          d[k] = (pos >= 0 && pos < w) ? ex[k][h][23-pos] : (i[0] ^ k[0]);
        bit_cycle(lr, d);
      end
    end
    repeat (4) bit_cycle(~lvl_l, 4'h0);
    check(rx_n == 8, req, "sample count", 32'(rx_n), 32'd8);
    for (int j = 0; j < 8 && j < rx_n; j++) begin
      check(rx_c[j] == 3'(2 * (j % 4) + j / 4), "R5,R6", "channel order",
            32'(rx_c[j]), 32'(2 * (j % 4) + j / 4));
      check(rx_d[j] == ex[j % 4][j / 4], req, "sample data",
            32'(rx_d[j]), 32'(ex[j % 4][j / 4]));
    end
  endtask

  task automatic run_tdm(input int seed);
    logic [23:0] ex [8];
    logic [3:0] d;
    int slot, b;
    @(negedge clk_i);
    mode_i = 2'd3;
    for (int s = 0; s < 8; s++) ex[s] = mk_word(0, s, seed, 24);
    repeat (4) bit_cycle(1'b0, 4'h0);
    rx_n = 0;
    for (int i = 0; i < 256; i++) begin
      slot = i / 32; b = i % 32;
      d[0]   = (b < 24) ? ex[slot][23-b] : b[0];
      d[3:1] = 3'(i * 5);
      bit_cycle(i == 0, d);
    end
    repeat (4) bit_cycle(1'b0, 4'h0);
    check(rx_n == 8, "R7", "slot count (lanes 1-3 silent)", 32'(rx_n), 32'd8);
    for (int j = 0; j < 8 && j < rx_n; j++) begin
      check(rx_c[j] == 3'(j), "R7", "slot channel", 32'(rx_c[j]), 32'(j));
      check(rx_d[j] == ex[j], "R7", "slot data", 32'(rx_d[j]), 32'(ex[j]));
    end
  endtask

  initial begin
    run_reset_quiet();
    run_stereo(2'd0, 2'd0, 3, "R1");
    run_stereo(2'd0, 2'd0, 11, "R5");
    run_stereo(2'd1, 2'd0, 5, "R2");
    run_stereo(2'd2, 2'd0, 7, "R3");
    run_stereo(2'd2, 2'd1, 9, "R3");
    run_stereo(2'd2, 2'd2, 13, "R4");
    run_stereo(2'd2, 2'd3, 17, "R4");
    run_tdm(21);
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule